// File: doc/BRIEF.md
# Effective Address Unit

This block works out where one operand of a 68000-style instruction lives. A decoder hands it a 5-bit addressing-mode code, a 3-bit register number, an operand size, a quick constant and the program counter of the first extension word. The unit reads the data and address register file through one combinational read port. It pulls any extension words through a request/valid fetch port and advances its copy of the program counter by two for each word it accepts. When it finishes it returns a 32-bit result and a flag. The flag tells the caller whether the result is a memory address or the operand value itself.

In the auto-increment and auto-decrement modes the unit also issues one write-back to the address register. The step depends on the operand size, and a byte access on the stack register (address register 7) steps by two so that the stack stays word aligned. In the indexed modes the unit decodes the brief index extension word: it chooses the index register, optionally sign-extends a 16-bit index, and adds a signed 8-bit displacement.

The control is a state machine with these states:
- ST_IDLE: waits for `start`.
- ST_BASE: reads the base register or snapshots the program counter.
- ST_EXT_HI: fetches the upper word of a 32-bit extension.
- ST_EXT_LO: fetches the last or only extension word.
- ST_INDEX: reads the index register and forms the sum.
- ST_DONE: presents the result for one cycle.

The transitions are:
- IDLE→BASE on `start`.
- BASE→DONE for register-based and unsupported modes.
- BASE→EXT_HI for absolute long and for long immediates.
- BASE→EXT_LO for every other mode that takes an extension word.
- EXT_HI→EXT_LO on an accepted word.
- EXT_LO→INDEX for indexed modes, or EXT_LO→DONE, on an accepted word.
- INDEX→DONE.
- DONE→IDLE.

Top module: `opnd_loc_gen`

## Requirements
- R1: After reset `done`, `fetch_req` and `an_wr_en` are low. `start` is taken only in ST_IDLE; a `start` pulse while a calculation is running has no effect, and each accepted `start` yields exactly one `done` pulse.
- R2: Mode 00000 returns data register `reg_num`. Mode 00001 returns address register `reg_num`. Mode 01101 returns `quick_value`. All three clear `is_addr`, fetch nothing and leave `pc_out` equal to `pc_in`.
- R3: Immediate mode 01100 returns an operand value with `is_addr` clear. Size codes are byte=00, word=01, long=10. Byte returns the low 8 bits of one fetched word, zero-extended. Word returns that word, zero-extended. Long returns two words, the first fetched in the upper half. `pc_out` is `pc_in`+2 for byte and word and `pc_in`+4 for long.
- R4: Mode 00010 returns the address register as an address with `is_addr` set.
- R5: Mode 00011 returns the old register value as the address. It writes back that value plus 1, 2 or 4 for byte, word or long, with `an_wr_en` high only during the `done` cycle.
- R6: Mode 00100 subtracts 1, 2 or 4 from the register and returns the new value both as the address and as the write-back data.
- R7: For a byte access on address register 7, modes 00011 and 00100 step by 2.
- R8: Mode 01000 fetches one word and sign-extends it. Mode 01001 fetches two words, upper first, and uses them as they are. `pc_out` advances by 2 or 4 respectively.
- R9: Mode 00101 adds a sign-extended word to the address register. Mode 01010 adds it to `pc_in`, which is the program counter before that word is consumed.
- R10: Modes 00110 (address register base) and 01011 (`pc_in` base) return base + sign-extended bits 7:0 + index. The index comes from the extension word: bit 15 picks an address (1) or data (0) register, bits 14:12 give its number, and bit 11 picks the full 32 bits (1) or the low 16 bits sign-extended (0).
- R11: The unit holds `fetch_req` until `fetch_valid` arrives, and `pc_out` grows by exactly 2 per accepted word. `done` lasts one cycle.
- R12: Any other mode code returns 0 with `is_addr` clear, fetches nothing and writes nothing back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (taken in ST_IDLE) |
| mode | input | 5 | Addressing-mode code |
| reg_num | input | 3 | Register number for the mode |
| op_size | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| pc_in | input | XLEN | Program counter at the first extension word |
| quick_value | input | XLEN | Constant returned in quick mode |
| rf_rd_sel | output | 4 | Register read select: bit 3 address(1)/data(0), bits 2:0 number |
| rf_rd_data | input | XLEN | Combinational register read data |
| an_wr_en | output | 1 | Address register write-back strobe |
| an_wr_idx | output | 3 | Address register being written |
| an_wr_data | output | XLEN | Write-back value |
| fetch_req | output | 1 | Extension word request |
| fetch_addr | output | XLEN | Address of the requested word |
| fetch_data | input | 16 | Returned extension word |
| fetch_valid | input | 1 | Word valid; completes the request |
| done | output | 1 | One-cycle completion pulse |
| ea_value | output | XLEN | Computed address or operand value |
| is_addr | output | 1 | Set when `ea_value` is a memory address |
| pc_out | output | XLEN | Program counter after consumed words |

## Verification
If the base or index register were mixed up, or a field of the index word were misdecoded, the error would show at once in `ea_value` in the `done` cycle of that one calculation. A wrong step size would show in `an_wr_data` in the same cycle. A state that miscounted extension words would show as a `pc_out` off by a multiple of two, or as a `done` pulse that comes too early or twice. A missed wait on `fetch_valid` would latch stale fetch data, because the bench inserts idle cycles between requests and responses. Starts injected while the unit is busy would surface as an extra `done` within a few cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int MODE_W = 5;
    localparam int REG_W  = 3;
    localparam int EXT_W  = 16;
    localparam int DISP_W = 8;
    localparam logic [REG_W-1:0] STACK_REG = 3'd7;

    localparam logic [MODE_W-1:0] MD_DREG   = 5'b00000;
    localparam logic [MODE_W-1:0] MD_AREG   = 5'b00001;
    localparam logic [MODE_W-1:0] MD_AIND   = 5'b00010;
    localparam logic [MODE_W-1:0] MD_APOST  = 5'b00011;
    localparam logic [MODE_W-1:0] MD_APRE   = 5'b00100;
    localparam logic [MODE_W-1:0] MD_ADISP  = 5'b00101;
    localparam logic [MODE_W-1:0] MD_AIDX   = 5'b00110;
    localparam logic [MODE_W-1:0] MD_ABSW   = 5'b01000;
    localparam logic [MODE_W-1:0] MD_ABSL   = 5'b01001;
    localparam logic [MODE_W-1:0] MD_PCDISP = 5'b01010;
    localparam logic [MODE_W-1:0] MD_PCIDX  = 5'b01011;
    localparam logic [MODE_W-1:0] MD_IMM    = 5'b01100;
    localparam logic [MODE_W-1:0] MD_QUICK  = 5'b01101;

    localparam logic [1:0] SZ_B = 2'b00;
    localparam logic [1:0] SZ_W = 2'b01;
    localparam logic [1:0] SZ_L = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_EXT_HI,
        ST_EXT_LO,
        ST_INDEX,
        ST_DONE
    } st_e;
endpackage

// File: rtl/ea_step.sv
module ea_step
    import ea_pkg::*;
(
    input  logic [1:0] size,
    input  logic       is_stack,
    output logic [2:0] step
);
    always_comb begin
        unique case (size)
            SZ_B:    step = is_stack ? 3'd2 : 3'd1;
            SZ_W:    step = 3'd2;
            default: step = 3'd4;
        endcase
    end
endmodule

// File: rtl/ea_index_sum.sv
module ea_index_sum
    import ea_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base,
    input  logic [EXT_W-1:0] ext,
    input  logic [XLEN-1:0]  idx_data,
    output logic [REG_W:0]   idx_sel,
    output logic [XLEN-1:0]  sum
);
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] disp_term;

    always_comb begin
        idx_sel   = {ext[15], ext[14:12]};
        idx_term  = ext[11] ? idx_data
                            : {{(XLEN-EXT_W){idx_data[EXT_W-1]}}, idx_data[EXT_W-1:0]};
        disp_term = {{(XLEN-DISP_W){ext[DISP_W-1]}}, ext[DISP_W-1:0]};
        sum       = base + disp_term + idx_term;
    end
endmodule

// File: rtl/opnd_loc_gen.sv
module opnd_loc_gen
    import ea_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [1:0]        op_size,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   quick_value,
    output logic [REG_W:0]    rf_rd_sel,
    input  logic [XLEN-1:0]   rf_rd_data,
    output logic              an_wr_en,
    output logic [REG_W-1:0]  an_wr_idx,
    output logic [XLEN-1:0]   an_wr_data,
    output logic              fetch_req,
    output logic [XLEN-1:0]   fetch_addr,
    input  logic [EXT_W-1:0]  fetch_data,
    input  logic              fetch_valid,
    output logic              done,
    output logic [XLEN-1:0]   ea_value,
    output logic              is_addr,
    output logic [XLEN-1:0]   pc_out
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(EXT_W / 8);

    st_e               st_q, st_d;
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  reg_q;
    logic [1:0]        size_q;
    logic [XLEN-1:0]   quick_q, pc_q, base_q, val_q, wbdata_q;
    logic [EXT_W-1:0]  hi_q, ext_q;
    logic              isaddr_q, wb_q;

    logic [2:0]        step;
    logic [XLEN-1:0]   step_x, ext_sx, idx_sum;
    logic [REG_W:0]    idx_sel;
    logic              is_idx_mode, is_pc_mode, fetch_ok;

    ea_step u_step (
        .size     (size_q),
        .is_stack (reg_q == STACK_REG),
        .step     (step)
    );

    ea_index_sum #(.XLEN(XLEN)) u_index (
        .base     (base_q),
        .ext      (ext_q),
        .idx_data (rf_rd_data),
        .idx_sel  (idx_sel),
        .sum      (idx_sum)
    );

    assign step_x      = XLEN'(step);
    assign ext_sx      = {{(XLEN-EXT_W){fetch_data[EXT_W-1]}}, fetch_data};
    assign is_idx_mode = (mode_q == MD_AIDX) || (mode_q == MD_PCIDX);
    assign is_pc_mode  = (mode_q == MD_PCDISP) || (mode_q == MD_PCIDX);
    assign fetch_ok    = fetch_req && fetch_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_BASE;
            ST_BASE: begin
                case (mode_q)
                    MD_ADISP, MD_AIDX, MD_PCDISP, MD_PCIDX, MD_ABSW: st_d = ST_EXT_LO;
                    MD_ABSL: st_d = ST_EXT_HI;
                    MD_IMM:  st_d = (size_q == SZ_L) ? ST_EXT_HI : ST_EXT_LO;
                    default: st_d = ST_DONE;
                endcase
            end
            ST_EXT_HI: if (fetch_valid) st_d = ST_EXT_LO;
            ST_EXT_LO: if (fetch_valid) st_d = is_idx_mode ? ST_INDEX : ST_DONE;
            ST_INDEX:  st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reg_q    <= '0;
            size_q   <= '0;
            quick_q  <= '0;
            pc_q     <= '0;
            base_q   <= '0;
            val_q    <= '0;
            wbdata_q <= '0;
            hi_q     <= '0;
            ext_q    <= '0;
            isaddr_q <= 1'b0;
            wb_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode;
                        reg_q   <= reg_num;
                        size_q  <= op_size;
                        quick_q <= quick_value;
                        pc_q    <= pc_in;
                        wb_q    <= 1'b0;
                    end
                end
                ST_BASE: begin
                    base_q   <= is_pc_mode ? pc_q : rf_rd_data;
                    val_q    <= '0;
                    isaddr_q <= 1'b0;
                    case (mode_q)
                        MD_DREG, MD_AREG: val_q <= rf_rd_data;
                        MD_QUICK: val_q <= quick_q;
                        MD_AIND: begin
                            val_q    <= rf_rd_data;
                            isaddr_q <= 1'b1;
                        end
                        MD_APOST: begin
                            val_q    <= rf_rd_data;
                            isaddr_q <= 1'b1;
                            wb_q     <= 1'b1;
                            wbdata_q <= rf_rd_data + step_x;
                        end
                        MD_APRE: begin
                            val_q    <= rf_rd_data - step_x;
                            isaddr_q <= 1'b1;
                            wb_q     <= 1'b1;
                            wbdata_q <= rf_rd_data - step_x;
                        end
                        default: ;
                    endcase
                end
                ST_EXT_HI: begin
                    if (fetch_valid) begin
                        hi_q <= fetch_data;
                        pc_q <= pc_q + WORD_BYTES;
                    end
                end
                ST_EXT_LO: begin
                    if (fetch_valid) begin
                        pc_q  <= pc_q + WORD_BYTES;
                        ext_q <= fetch_data;
                        case (mode_q)
                            MD_ABSW: begin
                                val_q    <= ext_sx;
                                isaddr_q <= 1'b1;
                            end
                            MD_ABSL: begin
                                val_q    <= XLEN'({hi_q, fetch_data});
                                isaddr_q <= 1'b1;
                            end
                            MD_IMM: begin
                                if (size_q == SZ_B)      val_q <= XLEN'(fetch_data[7:0]);
                                else if (size_q == SZ_W) val_q <= XLEN'(fetch_data);
                                else                     val_q <= XLEN'({hi_q, fetch_data});
                            end
                            MD_ADISP, MD_PCDISP: begin
                                val_q    <= base_q + ext_sx;
                                isaddr_q <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_INDEX: begin
                    val_q    <= idx_sum;
                    isaddr_q <= 1'b1;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rf_rd_sel  = (st_q == ST_INDEX) ? idx_sel : {(mode_q != MD_DREG), reg_q};
        fetch_req  = (st_q == ST_EXT_HI) || (st_q == ST_EXT_LO);
        fetch_addr = pc_q;
        done       = (st_q == ST_DONE);
        an_wr_en   = done && wb_q;
        an_wr_idx  = reg_q;
        an_wr_data = wbdata_q;
        ea_value   = val_q;
        is_addr    = isaddr_q;
        pc_out     = pc_q;
    end

    // R11: completion is a single-cycle pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: each accepted extension word moves the program counter by one word
    assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |=> (pc_out == $past(pc_out) + WORD_BYTES));

    // R11: without a fetch or a new start the program counter holds
    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ok && !(st_q == ST_IDLE && start)) |=> $stable(pc_out));

    // R5: write-back appears only with completion
    assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        an_wr_en |-> done);

    // R7: byte post-increment on the stack register steps by two
    assert_sp_byte_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (an_wr_en && an_wr_idx == STACK_REG && size_q == SZ_B && mode_q == MD_APOST)
            |-> (an_wr_data == ea_value + XLEN'(2)));

    // R2: direct and quick modes never report an address
    assert_value_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == MD_DREG || mode_q == MD_AREG || mode_q == MD_QUICK)) |-> !is_addr);
endmodule

// File: tb/opnd_loc_gen_test.sv
`timescale 1ns/1ps
module opnd_loc_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  mode = '0;
    logic [2:0]  reg_num = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] quick_value = '0;
    logic [3:0]  rf_rd_sel;
    logic [31:0] rf_rd_data;
    logic        an_wr_en;
    logic [2:0]  an_wr_idx;
    logic [31:0] an_wr_data;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic [15:0] fetch_data = '0;
    logic        fetch_valid = 1'b0;
    logic        done;
    logic [31:0] ea_value;
    logic        is_addr;
    logic [31:0] pc_out;

    always #2.5 clk = ~clk;

    opnd_loc_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
        .op_size(op_size), .pc_in(pc_in), .quick_value(quick_value),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .an_wr_en(an_wr_en), .an_wr_idx(an_wr_idx), .an_wr_data(an_wr_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_valid(fetch_valid), .done(done), .ea_value(ea_value),
        .is_addr(is_addr), .pc_out(pc_out)
    );

    // Register file and instruction stream models
    logic [31:0] dreg [8];
    logic [31:0] areg [8];
    logic [15:0] stream [2];
    logic [31:0] stream_base;

    assign rf_rd_data = rf_rd_sel[3] ? areg[rf_rd_sel[2:0]] : dreg[rf_rd_sel[2:0]];

    always @(posedge clk) if (an_wr_en) areg[an_wr_idx] <= an_wr_data;

    // Responder: answers every other cycle so the unit has to wait
    always @(negedge clk) begin
        if (fetch_req && !fetch_valid) begin
            fetch_valid <= 1'b1;
            fetch_data  <= stream[1'((fetch_addr - stream_base) >> 1)];
        end else begin
            fetch_valid <= 1'b0;
        end
    end

    typedef struct {
        logic [31:0] val;
        logic        isa;
        logic [31:0] pc;
        logic        wb;
        logic [31:0] wdata;
        logic [2:0]  widx;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int fails  = 0;
    int extra_done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                extra_done++;
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(ea_value == e.val, e.tag, "ea_value", ea_value, e.val);
                chk(is_addr == e.isa, e.tag, "is_addr", 32'(is_addr), 32'(e.isa));
                chk(pc_out == e.pc, e.tag, "pc_out", pc_out, e.pc);
                chk(an_wr_en == e.wb, e.tag, "an_wr_en", 32'(an_wr_en), 32'(e.wb));
                if (e.wb) begin
                    chk(an_wr_data == e.wdata, e.tag, "an_wr_data", an_wr_data, e.wdata);
                    chk(an_wr_idx == e.widx, e.tag, "an_wr_idx", 32'(an_wr_idx), 32'(e.widx));
                end
            end
        end
    end

    // Driver
    task automatic run(input logic [4:0] m, input logic [2:0] r, input logic [1:0] sz,
                       input logic [31:0] qv, input logic [31:0] pc,
                       input logic [15:0] e0, input logic [15:0] e1,
                       input logic [31:0] xv, input logic xa, input logic [31:0] xpc,
                       input logic xwb, input logic [31:0] xwd, input string tag,
                       input bit poke);
        exp_t e;
        e.val = xv; e.isa = xa; e.pc = xpc; e.wb = xwb; e.wdata = xwd; e.widx = r; e.tag = tag;
        stream[0] = e0; stream[1] = e1; stream_base = pc;
        sbq.push_back(e);
        mode = m; reg_num = r; op_size = sz; quick_value = qv; pc_in = pc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            mode = 5'b00000; pc_in = 32'hDEAD_0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sbq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin dreg[i] = '0; areg[i] = '0; end
        stream[0] = '0; stream[1] = '0; stream_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
        chk(fetch_req == 1'b0, "R1", "fetch_req after reset", 32'(fetch_req), 0);
        chk(an_wr_en == 1'b0, "R1", "an_wr_en after reset", 32'(an_wr_en), 0);

        // R2 direct and quick
        dreg[3] = 32'h1234_5678;
        run(5'b00000, 3, 2'b01, 0, 32'h1000, 0, 0, 32'h1234_5678, 0, 32'h1000, 0, 0, "R2", 0);
        areg[5] = 32'hCAFE_0000;
        run(5'b00001, 5, 2'b10, 0, 32'h1000, 0, 0, 32'hCAFE_0000, 0, 32'h1000, 0, 0, "R2", 0);
        run(5'b01101, 0, 2'b10, 7, 32'h1000, 0, 0, 32'h7, 0, 32'h1000, 0, 0, "R2", 0);

        // R3 immediate
        run(5'b01100, 0, 2'b00, 0, 32'h1000, 16'hAB12, 0, 32'h12, 0, 32'h1002, 0, 0, "R3", 0);
        run(5'b01100, 0, 2'b01, 0, 32'h1000, 16'hBEEF, 0, 32'hBEEF, 0, 32'h1002, 0, 0, "R3", 0);
        run(5'b01100, 0, 2'b10, 0, 32'h1000, 16'h1234, 16'h5678, 32'h1234_5678, 0, 32'h1004, 0, 0, "R3", 0);

        // R4 indirect
        areg[2] = 32'h1000_0010;
        run(5'b00010, 2, 2'b01, 0, 32'h1000, 0, 0, 32'h1000_0010, 1, 32'h1000, 0, 0, "R4", 0);

        // R5 post-increment
        areg[1] = 32'h2000;
        run(5'b00011, 1, 2'b01, 0, 32'h1000, 0, 0, 32'h2000, 1, 32'h1000, 1, 32'h2002, "R5", 0);
        chk(areg[1] == 32'h2002, "R5", "register after write-back", areg[1], 32'h2002);
        areg[1] = 32'h3000;
        run(5'b00011, 1, 2'b10, 0, 32'h1000, 0, 0, 32'h3000, 1, 32'h1000, 1, 32'h3004, "R5", 0);
        areg[0] = 32'h40;
        run(5'b00011, 0, 2'b00, 0, 32'h1000, 0, 0, 32'h40, 1, 32'h1000, 1, 32'h41, "R5", 0);

        // R6 pre-decrement
        areg[3] = 32'h100;
        run(5'b00100, 3, 2'b10, 0, 32'h1000, 0, 0, 32'hFC, 1, 32'h1000, 1, 32'hFC, "R6", 0);
        areg[4] = 32'h0;
        run(5'b00100, 4, 2'b01, 0, 32'h1000, 0, 0, 32'hFFFF_FFFE, 1, 32'h1000, 1, 32'hFFFF_FFFE, "R6", 0);

        // R7 stack register byte steps
        areg[7] = 32'h8000;
        run(5'b00011, 7, 2'b00, 0, 32'h1000, 0, 0, 32'h8000, 1, 32'h1000, 1, 32'h8002, "R7", 0);
        areg[7] = 32'h8000;
        run(5'b00100, 7, 2'b00, 0, 32'h1000, 0, 0, 32'h7FFE, 1, 32'h1000, 1, 32'h7FFE, "R7", 0);

        // R8 absolute, with R1 start poke during the long fetch
        run(5'b01000, 0, 2'b01, 0, 32'h1000, 16'h8000, 0, 32'hFFFF_8000, 1, 32'h1002, 0, 0, "R8", 0);
        run(5'b01000, 0, 2'b01, 0, 32'h1000, 16'h1234, 0, 32'h1234, 1, 32'h1002, 0, 0, "R8", 0);
        run(5'b01001, 0, 2'b01, 0, 32'h1000, 16'h00AB, 16'hCDEF, 32'h00AB_CDEF, 1, 32'h1004, 0, 0, "R8", 1);

        // R9 displacement
        areg[4] = 32'h0001_0000;
        run(5'b00101, 4, 2'b01, 0, 32'h1000, 16'hFFFE, 0, 32'h0000_FFFE, 1, 32'h1002, 0, 0, "R9", 0);
        run(5'b01010, 0, 2'b01, 0, 32'h400, 16'h0010, 0, 32'h410, 1, 32'h402, 0, 0, "R9", 0);

        // R10 index word
        areg[6] = 32'h3000; dreg[2] = 32'h100;
        run(5'b00110, 6, 2'b01, 0, 32'h1000, 16'h28F0, 0, 32'h30F0, 1, 32'h1002, 0, 0, "R10", 0);
        dreg[5] = 32'h0001_FFFC;
        run(5'b00110, 6, 2'b01, 0, 32'h1000, 16'h5004, 0, 32'h3000, 1, 32'h1002, 0, 0, "R10", 0);
        dreg[1] = 32'hFFFF_0010;
        run(5'b00110, 6, 2'b01, 0, 32'h1000, 16'h1000, 0, 32'h3010, 1, 32'h1002, 0, 0, "R10", 0);
        areg[7] = 32'h20;
        run(5'b01011, 0, 2'b01, 0, 32'h500, 16'hF802, 0, 32'h522, 1, 32'h502, 0, 0, "R10", 0);

        // R12 unsupported code
        run(5'b11111, 2, 2'b10, 0, 32'h1000, 0, 0, 32'h0, 0, 32'h1000, 0, 0, "R12", 0);

        // R1 / R11: no extra completion pulses anywhere
        chk(extra_done == 0, "R1", "unexpected done pulses", 32'(extra_done), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule